// File: doc/BRIEF.md
# Four-Bit Combinational ALU with Carry Flag

This block is the arithmetic and logic core of a small teaching CPU. It takes two operand words and a three-bit operation code and returns, through logic alone, a result word of the same width together with a carry flag. There is no clock and no state. The result settles a few gate delays after any input changes, and the enclosing datapath captures it in its own registers.

Addition and subtraction use one ripple chain of full adders, and each full adder is built from two half adders. A subtract control inverts every bit of the second operand and also drives the carry into the lowest stage, so the chain computes A + ~B + 1. The carry leaving the top stage becomes the flag, which lets software chain several words for multi-precision sums. The remaining operations are three bitwise logic functions and four one-place shifts: logical left, logical right, arithmetic right and rotate right. A separate rotate control turns the arithmetic-right code into rotate right. Every result is truncated to the operand width, which is a parameter with a default of 4.

Top module: `mini_alu`

## Requirements
- R1: Code 000 (add) gives result = (A + B) mod 2^W and carry = the carry out of the top bit; 1001 + 0111 gives 0000 with carry 1.
- R2: Code 001 (subtract) gives result = (A - B) mod 2^W, computed as A + ~B + 1, and carry = 1 exactly when A >= B as unsigned numbers; 0110 - 0001 gives 0101 with carry 1.
- R3: Codes 010, 011 and 100 give bitwise AND, OR and XOR of A and B, and carry = 0.
- R4: Code 101 (logical shift left) shifts A up one place, puts 0 in the LSB, and gives carry = the old MSB of A; 0101 gives 1010.
- R5: Code 110 (logical shift right) shifts A down one place, puts 0 in the MSB, and gives carry = the old LSB of A; 1010 gives 0101.
- R6: Code 111 with the rotate control at 0 (arithmetic shift right) shifts A down one place, keeps the old MSB in the MSB, and gives carry = the old LSB.
- R7: Code 111 with the rotate control at 1 (rotate right) moves the old LSB of A into the MSB and the other bits down one place, and gives carry = the old LSB; 1011 gives 1101.
- R8: For codes 000 to 110 the rotate control has no effect on the result or on the carry.
- R9: For the shift codes 101, 110 and 111, operand B has no effect on the result or on the carry.
- R10: The outputs depend on the present inputs only. A change of input is visible at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand; the only operand used by shifts |
| opnd_b | input | W | Second operand |
| op_sel | input | 3 | Operation code (see R1 to R7) |
| rot_en | input | 1 | Selects rotate right in place of arithmetic shift right for code 111 |
| result | output | W | Result, truncated to W bits |
| carry_out | output | 1 | Adder carry, shifted-out bit, or 0 for logic operations |

## Verification
The subtract path is the hardest to reach. The carry flag has to report "no borrow" on the boundary A == B as well as on both sides of it, and the raw carry of A + ~B + 1 is easy to invert or to take from the wrong stage. The bench drives every operand pair under every code and both settings of the rotate control, so every A == B pair and every one-apart pair reaches the subtractor. It also drives the rotate control against the seven codes where it must be ignored, and it varies B under the shift codes, so a stray dependence shows up at the result and carry ports.

// File: rtl/mini_alu_pkg.sv
// Package: shared operation and shift-kind encodings for the ALU.
// Assumes: the operation code is three bits wide; the codes are fixed by R1 to R7.
package mini_alu_pkg;

    // Operation select codes seen at the op_sel port.
    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_LSL = 3'b101,
        OP_LSR = 3'b110,
        OP_ASR = 3'b111
    } alu_op_e;

    // Internal selection of the one-place shift variant.
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    // Internal selection of the bitwise logic function.
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

endpackage

// File: rtl/alu_half_add.sv
// Module: one-bit half adder.
// What it does: the sum is the XOR of the two inputs; the carry is their AND.
// Assumes: nothing; purely combinational.
module alu_half_add (
    input  logic in_x,
    input  logic in_y,
    output logic sum_o,
    output logic cry_o
);

    // Sum and carry gates.
    always_comb begin
        sum_o = in_x ^ in_y;
        cry_o = in_x & in_y;
    end

endmodule

// File: rtl/alu_full_add.sv
// Module: one-bit full adder made of two half adders.
// What it does: adds two bits and a carry-in. The first half adder adds the
// operand bits and the second adds the carry-in to that partial sum.
// Assumes: nothing; purely combinational.
module alu_full_add (
    input  logic in_x,
    input  logic in_y,
    input  logic cry_i,
    output logic sum_o,
    output logic cry_o
);

    logic part_sum;
    logic part_cry0;
    logic part_cry1;

    alu_half_add ha_lo_i (
        .in_x  (in_x),
        .in_y  (in_y),
        .sum_o (part_sum),
        .cry_o (part_cry0)
    );

    alu_half_add ha_hi_i (
        .in_x  (part_sum),
        .in_y  (cry_i),
        .sum_o (sum_o),
        .cry_o (part_cry1)
    );

    // The two half-adder carries can never both be 1, so OR merges them.
    always_comb begin
        cry_o = part_cry0 | part_cry1;
    end

endmodule

// File: rtl/alu_addsub.sv
// Module: ripple-carry adder/subtractor.
// What it does: with sub_mode = 0 it computes a + b; with sub_mode = 1 it
// computes a + ~b + 1. Each bit of b is XORed with sub_mode, and sub_mode is
// also the carry into stage 0. carry_o is the carry out of the top stage.
// Assumes: WIDTH >= 1.
module alu_addsub #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    localparam int CHAIN_LEN = WIDTH + 1;

    logic [WIDTH-1:0]     y_cond;
    logic [CHAIN_LEN-1:0] chain;

    // Conditional inversion of the second operand, and the carry-in.
    always_comb begin
        y_cond   = opnd_y ^ {WIDTH{sub_mode}};
        chain[0] = sub_mode;
    end

    // One full adder per bit; each carry feeds the next stage.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_stage
        alu_full_add fa_i (
            .in_x  (opnd_x[gi]),
            .in_y  (y_cond[gi]),
            .cry_i (chain[gi]),
            .sum_o (sum_o[gi]),
            .cry_o (chain[gi+1])
        );
    end

    // The carry out of the top stage is exported.
    always_comb begin
        carry_o = chain[WIDTH];
    end

    // The gate-level chain must agree with a wide arithmetic sum.
    always_comb begin
        if (!$isunknown({opnd_x, opnd_y, sub_mode})) begin
            AST_CHAIN_MATCHES_SUM: assert ({carry_o, sum_o} ==
                (CHAIN_LEN'(opnd_x) + CHAIN_LEN'(opnd_y ^ {WIDTH{sub_mode}}) + CHAIN_LEN'(sub_mode))); // R1
        end
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise logic functions.
// What it does: applies AND, OR or XOR to each bit pair on its own,
// with no interaction between bit positions.
// Assumes: kind_i takes only the three defined values; any other value gives 0.
module alu_logic_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]                opnd_x,
    input  logic [WIDTH-1:0]                opnd_y,
    input  mini_alu_pkg::logic_kind_e       kind_i,
    output logic [WIDTH-1:0]                res_o
);

    import mini_alu_pkg::*;

    // Per-bit gate selection.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        always_comb begin
            case (kind_i)
                LG_AND:  res_o[gi] = opnd_x[gi] & opnd_y[gi];
                LG_OR:   res_o[gi] = opnd_x[gi] | opnd_y[gi];
                LG_XOR:  res_o[gi] = opnd_x[gi] ^ opnd_y[gi];
                default: res_o[gi] = 1'b0;
            endcase
        end
    end

    // An AND result can never hold a 1 where the OR result would not.
    always_comb begin
        if (!$isunknown({opnd_x, opnd_y, kind_i}) && kind_i == LG_AND) begin
            AST_AND_WITHIN_OR: assert ((res_o & ~(opnd_x | opnd_y)) == '0); // R3
        end
    end

endmodule

// File: rtl/alu_shift_unit.sv
// Module: one-place shifter.
// What it does: logical left, logical right, arithmetic right or rotate right
// of opnd_x by one place. out_bit_o is the bit that leaves the word: the old
// MSB for the left shift and the old LSB for the three right-going variants.
// Assumes: WIDTH >= 2.
module alu_shift_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]          opnd_x,
    input  mini_alu_pkg::shift_kind_e kind_i,
    output logic [WIDTH-1:0]          res_o,
    output logic                      out_bit_o
);

    import mini_alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic fill_top;

    // Choose what enters the MSB on a right-going shift.
    always_comb begin
        case (kind_i)
            SH_ASR:  fill_top = opnd_x[MSB];
            SH_ROR:  fill_top = opnd_x[0];
            default: fill_top = 1'b0;
        endcase
    end

    // Form the shifted word and the bit that leaves it.
    always_comb begin
        if (kind_i == SH_LSL) begin
            res_o     = {opnd_x[MSB-1:0], 1'b0};
            out_bit_o = opnd_x[MSB];
        end else begin
            res_o     = {fill_top, opnd_x[MSB:1]};
            out_bit_o = opnd_x[0];
        end
    end

    // Properties of each shift variant.
    always_comb begin
        if (!$isunknown({opnd_x, kind_i})) begin
            if (kind_i == SH_LSL) begin
                AST_LSL_ZERO_FILL: assert (res_o[0] == 1'b0 && out_bit_o == opnd_x[MSB]); // R4
            end
            if (kind_i == SH_LSR) begin
                AST_LSR_ZERO_FILL: assert (res_o[MSB] == 1'b0 && out_bit_o == opnd_x[0]); // R5
            end
            if (kind_i == SH_ASR) begin
                AST_ASR_KEEPS_SIGN: assert (res_o[MSB] == opnd_x[MSB]); // R6
            end
            if (kind_i == SH_ROR) begin
                AST_ROR_KEEPS_ONES: assert ($countones(res_o) == $countones(opnd_x)); // R7
            end
        end
    end

endmodule

// File: rtl/mini_alu.sv
// Module: top of the combinational ALU.
// What it does: decodes op_sel (and rot_en for code 111), runs the
// adder/subtractor, the logic unit and the shifter side by side, and selects
// one result and one carry. There is no state and no clock.
// Assumes: WIDTH >= 2; the caller registers the outputs if it needs to.
module mini_alu #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic             rot_en,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    import mini_alu_pkg::*;

    alu_op_e          op_dec;
    logic             sub_mode;
    logic_kind_e      lg_kind;
    shift_kind_e      sh_kind;
    logic [WIDTH-1:0] as_sum;
    logic             as_carry;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] sh_res;
    logic             sh_out;

    // Decode the code into controls for each unit.
    always_comb begin
        op_dec   = alu_op_e'(op_sel);
        sub_mode = (op_dec == OP_SUB);
        case (op_dec)
            OP_OR:   lg_kind = LG_OR;
            OP_XOR:  lg_kind = LG_XOR;
            default: lg_kind = LG_AND;
        endcase
        case (op_dec)
            OP_LSL:  sh_kind = SH_LSL;
            OP_LSR:  sh_kind = SH_LSR;
            default: sh_kind = rot_en ? SH_ROR : SH_ASR;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) addsub_i (
        .opnd_x   (opnd_a),
        .opnd_y   (opnd_b),
        .sub_mode (sub_mode),
        .sum_o    (as_sum),
        .carry_o  (as_carry)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) logic_i (
        .opnd_x (opnd_a),
        .opnd_y (opnd_b),
        .kind_i (lg_kind),
        .res_o  (lg_res)
    );

    alu_shift_unit #(.WIDTH(WIDTH)) shift_i (
        .opnd_x    (opnd_a),
        .kind_i    (sh_kind),
        .res_o     (sh_res),
        .out_bit_o (sh_out)
    );

    // Select the result and the carry for the decoded operation.
    always_comb begin
        case (op_dec)
            OP_ADD, OP_SUB: begin
                result    = as_sum;
                carry_out = as_carry;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = lg_res;
                carry_out = 1'b0;
            end
            default: begin
                result    = sh_res;
                carry_out = sh_out;
            end
        endcase
    end

    // Checks on the selected outputs.
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel, rot_en})) begin
            if (op_dec == OP_AND || op_dec == OP_OR || op_dec == OP_XOR) begin
                AST_LOGIC_NO_CARRY: assert (carry_out == 1'b0); // R3
            end
            if (op_dec == OP_SUB) begin
                AST_SUB_NO_BORROW: assert (carry_out == (opnd_a >= opnd_b)); // R2
            end
        end
    end

endmodule

// File: tb/mini_alu_tb_top.sv
// Bench for mini_alu: a table of directed vectors, then an exhaustive sweep
// against a model written from the requirements, then directed corner checks.
module mini_alu_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [2:0]   op_in = '0;
    logic         rot_in = 1'b0;
    logic [W-1:0] res_out;
    logic         cry_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    mini_alu #(.WIDTH(W)) dut_i (
        .opnd_a    (a_in),
        .opnd_b    (b_in),
        .op_sel    (op_in),
        .rot_en    (rot_in),
        .result    (res_out),
        .carry_out (cry_out)
    );

    // Vector: {op[2:0], rot, a[3:0], b[3:0], res[3:0], carry}
    localparam int NV = 16;
    localparam logic [16:0] VECS [NV] = '{
        {3'b000, 1'b0, 4'b1001, 4'b0111, 4'b0000, 1'b1},
        {3'b000, 1'b0, 4'b1010, 4'b0101, 4'b1111, 1'b0},
        {3'b001, 1'b0, 4'b0110, 4'b0001, 4'b0101, 1'b1},
        {3'b001, 1'b0, 4'b0001, 4'b0110, 4'b1011, 1'b0},
        {3'b010, 1'b0, 4'b1100, 4'b1010, 4'b1000, 1'b0},
        {3'b011, 1'b0, 4'b1100, 4'b1010, 4'b1110, 1'b0},
        {3'b100, 1'b0, 4'b1100, 4'b1010, 4'b0110, 1'b0},
        {3'b101, 1'b0, 4'b0101, 4'b0000, 4'b1010, 1'b0},
        {3'b101, 1'b0, 4'b1100, 4'b0000, 4'b1000, 1'b1},
        {3'b110, 1'b0, 4'b1010, 4'b0000, 4'b0101, 1'b0},
        {3'b110, 1'b0, 4'b0011, 4'b0000, 4'b0001, 1'b1},
        {3'b111, 1'b0, 4'b1010, 4'b0000, 4'b1101, 1'b0},
        {3'b111, 1'b0, 4'b0111, 4'b0000, 4'b0011, 1'b1},
        {3'b111, 1'b1, 4'b1011, 4'b0000, 4'b1101, 1'b1},
        {3'b111, 1'b1, 4'b0100, 4'b0000, 4'b0010, 1'b0},
        {3'b010, 1'b1, 4'b1100, 4'b1010, 4'b1000, 1'b0}
    };

    // Requirement tag for an operation code.
    function automatic string req_of(input logic [2:0] op, input logic rot);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010, 3'b011, 3'b100: return rot ? "R8" : "R3";
            3'b101:  return rot ? "R8" : "R4";
            3'b110:  return rot ? "R8" : "R5";
            default: return rot ? "R7" : "R6";
        endcase
    endfunction

    // Model written from the requirements: returns {carry, result}.
    function automatic logic [W:0] model(input logic [2:0] op, input logic rot,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
        int ia = int'(a);
        int ib = int'(b);
        int s;
        case (op)
            3'b000: begin s = ia + ib; return {s >= 16, 4'(s)}; end
            3'b001: begin s = ia - ib; return {ia >= ib, 4'(s)}; end
            3'b010: return {1'b0, a & b};
            3'b011: return {1'b0, a | b};
            3'b100: return {1'b0, a ^ b};
            3'b101: return {a[3], a[2:0], 1'b0};
            3'b110: return {a[0], 1'b0, a[3:1]};
            default: return rot ? {a[0], a[0], a[3:1]} : {a[0], a[3], a[3:1]};
        endcase
    endfunction

    // Compare the outputs against expectations and count the result.
    task automatic check(input string tag, input logic [W-1:0] exp_r, input logic exp_c);
        n_tests++;
        if (res_out !== exp_r || cry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s: op=%b rot=%b a=%b b=%b got res=%b c=%b expected res=%b c=%b",
                     tag, op_in, rot_in, a_in, b_in, res_out, cry_out, exp_r, exp_c);
        end
    endtask

    // Drive inputs on the falling edge; the outputs are sampled 2 ns later.
    task automatic apply(input logic [2:0] op, input logic rot,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_in = op; rot_in = rot; a_in = a; b_in = b;
        #2;
    endtask

    initial begin : main
        logic [W:0] e;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: all inputs zero, so an add of 0 + 0 gives 0, carry 0 (R1).
        apply(3'b000, 1'b0, 4'd0, 4'd0);
        check("R1", 4'd0, 1'b0);

        // Walk the table of directed vectors.
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][16:14], VECS[i][13], VECS[i][12:9], VECS[i][8:5]);
            check(req_of(VECS[i][16:14], VECS[i][13]), VECS[i][4:1], VECS[i][0]);
        end

        // Every code, both rotate settings, and every operand pair.
        for (int op = 0; op < 8; op++) begin
            for (int r = 0; r < 2; r++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        apply(3'(op), 1'(r), 4'(a), 4'(b));
                        e = model(3'(op), 1'(r), 4'(a), 4'(b));
                        check(req_of(3'(op), 1'(r)), e[W-1:0], e[W]);
                    end
                end
            end
        end

        // Subtract boundary A == B: no borrow, result 0 (R2).
        apply(3'b001, 1'b0, 4'b1111, 4'b1111);
        check("R2", 4'b0000, 1'b1);

        // B has no effect on shifts (R9).
        apply(3'b111, 1'b0, 4'b1001, 4'b1111);
        check("R9", 4'b1100, 1'b1);
        apply(3'b101, 1'b0, 4'b1001, 4'b0110);
        check("R9", 4'b0010, 1'b1);

        // Rotate control ignored for code 000 (R8).
        apply(3'b000, 1'b1, 4'b1001, 4'b0111);
        check("R8", 4'b0000, 1'b1);

        // Outputs follow an input change with no clock edge between (R10).
        @(negedge clk);
        op_in = 3'b011; rot_in = 1'b0; a_in = 4'b0001; b_in = 4'b0100;
        #1;
        check("R10", 4'b0101, 1'b0);
        a_in = 4'b1000;
        #1;
        check("R10", 4'b1100, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule